// File: doc/BRIEF.md
# Password-Guarded Bus Coupler Gate

This block joins a near-side bus to a far-side bus. A transaction from the near-side initiator passes through a forwarding switch. When the switch is on, the transaction goes to the far side and the far-side reply comes back. When the switch is off, the transaction is refused locally with an error. A bus is isolated from the rest of the system once every coupler that touches it has its switch off. A broken coupler can therefore cut off only the two buses it joins.

Software controls the switch through a control write port. A command is accepted only when it directly follows a write of a fixed 16-bit key word. A runaway processor that writes arbitrary data cannot reopen a coupler that has been shut. The same guarded command can also raise a one-cycle reset strobe toward the far side. This lets a section be reset on its own, since there is no global reset line. Three status bits let software see the switch, the pending-key condition and a sticky record of refused commands.

Top module: `bus_coupler_gate`

## Requirements
- R1: After reset the switch is on, status bit 1 (armed) and status bit 2 (refused) are 0, and `far_rst_pulse`, `fwd_valid` and `rsp_valid` are all low.
- R2: A control write whose data equals `KEY` sets status bit 1 on the next cycle and leaves the switch unchanged.
- R3: While armed, a control write of any value other than `KEY` is taken as a command. The switch (status bit 0) takes data bit 0 (1 = forward), and armed clears, both on the next cycle.
- R4: A non-key control write while not armed leaves the switch unchanged and sets status bit 2. That bit stays set until reset.
- R5: Armed persists across cycles with no control write and is consumed by the next control write.
- R6: `far_rst_pulse` is high for exactly one cycle, on the cycle after an accepted command with data bit 1 set, and is never high otherwise.
- R7: With the switch on, a request appears on the far side one cycle later with unchanged write flag, address and data. The far-side reply is returned one cycle after it arrives, with `rsp_err` low.
- R8: With the switch off, a request is not forwarded. It is answered on the next cycle with `rsp_valid` and `rsp_err` high and read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control write strobe |
| csr_wdata | input | 16 | Control write data (key or command) |
| status | output | 3 | bit0 switch on, bit1 armed, bit2 refused write seen |
| far_rst_pulse | output | 1 | One-cycle reset strobe to the far side |
| req_valid | input | 1 | Near-side request (one outstanding at a time) |
| req_write | input | 1 | Request is a write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Request write data |
| rsp_valid | output | 1 | Near-side response valid |
| rsp_err | output | 1 | Response refused by the gate |
| rsp_rdata | output | 16 | Response read data |
| fwd_valid | output | 1 | Far-side request valid (one cycle) |
| fwd_write | output | 1 | Far-side write flag |
| fwd_addr | output | 16 | Far-side address |
| fwd_wdata | output | 16 | Far-side write data |
| fwd_rsp_valid | input | 1 | Far-side reply valid |
| fwd_rsp_rdata | input | 16 | Far-side reply data |

## Verification
A wrong switch state shows up at the near-side response one cycle after the next request. It appears either as an error reply where a forwarded transaction was expected, or as a far-side request that should have been blocked. A wrong armed state shows up on the status port one cycle after the control write that caused it. A wrong armed state also has a second symptom: a command that takes effect when it should have been refused, or one refused when it should have taken effect. That shows on the switch bit and the reset strobe one cycle after the command. The bench mixes random key, command and request traffic with directed sequences so that each of these mistakes reaches a port within two cycles.

// File: rtl/coupler_pkg.sv
package coupler_pkg;
  localparam int CMD_FWD_BIT = 0;
  localparam int CMD_RST_BIT = 1;
  localparam int STS_FWD_BIT = 0;
  localparam int STS_ARM_BIT = 1;
  localparam int STS_REJ_BIT = 2;
  localparam int STS_W       = 3;

  typedef struct packed {
    logic rejected;
    logic armed;
    logic fwd_on;
  } gate_state_t;
endpackage

// File: rtl/coupler_ctl.sv
module coupler_ctl
  import coupler_pkg::*;
#(
  parameter int          DW     = 16,
  parameter logic [15:0] KEY    = 16'hA5C3,
  parameter bit          ON_RST = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csr_we,
  input  logic [DW-1:0] csr_wdata,
  output gate_state_t   st,
  output logic          far_rst_pulse
);
  localparam logic [DW-1:0] KEY_W = DW'(KEY);

  logic key_hit;
  assign key_hit = (csr_wdata == KEY_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      st.fwd_on     <= ON_RST;
      st.armed      <= 1'b0;
      st.rejected   <= 1'b0;
      far_rst_pulse <= 1'b0;
    end else begin
      far_rst_pulse <= 1'b0;
      if (csr_we) begin
        if (key_hit) begin
          st.armed <= 1'b1;
        end else if (st.armed) begin
          st.armed      <= 1'b0;
          st.fwd_on     <= csr_wdata[CMD_FWD_BIT];
          far_rst_pulse <= csr_wdata[CMD_RST_BIT];
        end else begin
          st.rejected <= 1'b1;
        end
      end
    end
  end

  // R6: strobe lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    far_rst_pulse |=> !far_rst_pulse);
  // R6: strobe only after an armed command
  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(far_rst_pulse) |-> $past(st.armed) && $past(csr_we));
  // R4: switch holds unless an armed write came
  p_switch_guard_r4: assert property (@(posedge clk) disable iff (rst)
    !(st.armed && csr_we) |=> $stable(st.fwd_on));
  // R4: refused flag is sticky
  p_rej_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    st.rejected |=> st.rejected);
  // R3: a command consumes the armed state
  p_arm_consumed_r3: assert property (@(posedge clk) disable iff (rst)
    (st.armed && csr_we && !key_hit) |=> !st.armed);
  // R5: armed holds without control writes
  p_arm_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (st.armed && !csr_we) |=> st.armed);
endmodule

// File: rtl/coupler_fwd.sv
module coupler_fwd #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_on,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          fwd_valid,
  output logic          fwd_write,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_wdata,
  input  logic          fwd_rsp_valid,
  input  logic [DW-1:0] fwd_rsp_rdata
);
  logic busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      fwd_valid <= 1'b0;
      fwd_write <= 1'b0;
      fwd_addr  <= '0;
      fwd_wdata <= '0;
    end else begin
      fwd_valid <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (busy) begin
        if (fwd_rsp_valid) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= fwd_rsp_rdata;
        end
      end else if (req_valid) begin
        if (fwd_on) begin
          busy      <= 1'b1;
          fwd_valid <= 1'b1;
          fwd_write <= req_write;
          fwd_addr  <= req_addr;
          fwd_wdata <= req_wdata;
        end else begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_rdata <= '0;
        end
      end
    end
  end

  // R8: nothing leaves while inhibited
  p_block_inhib_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !fwd_on) |=> !fwd_valid && rsp_valid && rsp_err);
  // R7: far-side request is a single pulse
  p_fwd_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |=> !fwd_valid);
  // R7: forwarded reply never flagged as error
  p_fwd_noerr_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && fwd_rsp_valid) |=> rsp_valid && !rsp_err);
endmodule

// File: rtl/bus_coupler_gate.sv
module bus_coupler_gate
  import coupler_pkg::*;
#(
  parameter int          AW     = 16,
  parameter int          DW     = 16,
  parameter logic [15:0] KEY    = 16'hA5C3,
  parameter bit          ON_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic [DW-1:0]    csr_wdata,
  output logic [STS_W-1:0] status,
  output logic             far_rst_pulse,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic             fwd_valid,
  output logic             fwd_write,
  output logic [AW-1:0]    fwd_addr,
  output logic [DW-1:0]    fwd_wdata,
  input  logic             fwd_rsp_valid,
  input  logic [DW-1:0]    fwd_rsp_rdata
);
  gate_state_t st;

  coupler_ctl #(.DW(DW), .KEY(KEY), .ON_RST(ON_RST)) u_ctl (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .st(st), .far_rst_pulse(far_rst_pulse)
  );

  coupler_fwd #(.AW(AW), .DW(DW)) u_fwd (
    .clk(clk), .rst(rst), .fwd_on(st.fwd_on),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write),
    .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata),
    .fwd_rsp_valid(fwd_rsp_valid), .fwd_rsp_rdata(fwd_rsp_rdata)
  );

  assign status[STS_FWD_BIT] = st.fwd_on;
  assign status[STS_ARM_BIT] = st.armed;
  assign status[STS_REJ_BIT] = st.rejected;

  // R1: quiet outputs right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !far_rst_pulse && !fwd_valid && !rsp_valid && !st.armed);
  // R2: key write arms the gate
  p_key_arms_r2: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_wdata == DW'(KEY)) |=> st.armed && $stable(st.fwd_on));
endmodule

// File: tb/tb_bus_coupler_gate.sv
module tb_bus_coupler_gate;
  localparam logic [15:0] PW = 16'hA5C3;

  logic clk = 0, rst = 1;
  logic csr_we = 0;
  logic [15:0] csr_wdata = 0;
  logic [2:0] status;
  logic far_rst_pulse;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic fwd_valid, fwd_write;
  logic [15:0] fwd_addr, fwd_wdata;
  logic fwd_rsp_valid = 0;
  logic [15:0] fwd_rsp_rdata = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit exp_en = 1, exp_arm = 0, exp_rej = 0;

  always #5 clk = ~clk;

  bus_coupler_gate #(.KEY(PW)) dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [2:0] exp_status();
    return {exp_rej, exp_arm, exp_en};
  endfunction

  task automatic csr_write(input logic [15:0] w);
    bit pulse = 0;
    csr_we = 1; csr_wdata = w;
    if (w == PW) exp_arm = 1;
    else if (exp_arm) begin
      exp_arm = 0; exp_en = w[0]; pulse = w[1];
    end else exp_rej = 1;
    step();
    csr_we = 0;
    check(status == exp_status(), "R2/R3/R4 status after control write", status, exp_status());
    check(far_rst_pulse == pulse, "R6 strobe after write", far_rst_pulse, pulse);
    step();
    check(far_rst_pulse == 0, "R6 strobe one cycle", far_rst_pulse, 0);
    check(status == exp_status(), "R5 status holds when idle", status, exp_status());
  endtask

  task automatic request(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [15:0] rd, input int lat);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    step();
    req_valid = 0;
    if (exp_en) begin
      check(fwd_valid && fwd_write == wr && fwd_addr == a && fwd_wdata == d,
            "R7 forwarded fields", {fwd_valid, fwd_addr}, {1'b1, a});
      check(!rsp_valid, "R7 no early response", rsp_valid, 0);
      for (int i = 0; i < lat; i++) begin
        step();
        check(!rsp_valid && !fwd_valid, "R7 quiet while waiting", rsp_valid, 0);
      end
      fwd_rsp_valid = 1; fwd_rsp_rdata = rd;
      step();
      fwd_rsp_valid = 0;
      check(rsp_valid && !rsp_err && rsp_rdata == rd, "R7 reply returned",
            {rsp_valid, rsp_err, rsp_rdata}, {2'b10, rd});
    end else begin
      check(!fwd_valid, "R8 not forwarded", fwd_valid, 0);
      check(rsp_valid && rsp_err && rsp_rdata == 0, "R8 error reply",
            {rsp_valid, rsp_err, rsp_rdata}, {2'b11, 16'h0});
    end
    step();
    check(!rsp_valid && !fwd_valid, "R7/R8 response single cycle", rsp_valid, 0);
  endtask

  function automatic logic [15:0] non_key(input logic [15:0] v);
    return (v == PW) ? ~v : v;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    check(status == 3'b001, "R1 status after reset", status, 3'b001);
    check(!far_rst_pulse && !fwd_valid && !rsp_valid, "R1 outputs quiet",
          {far_rst_pulse, fwd_valid, rsp_valid}, 0);
    request(1'b0, 16'h1234, 16'h0, 16'hBEEF, 0);         // R7
    csr_write(16'h0000);                                  // R4 unarmed command refused
    check(status[0] == 1, "R4 switch unchanged", status[0], 1);
    csr_write(PW);                                        // R2
    repeat (3) step();
    check(status[1] == 1, "R5 armed across idle cycles", status[1], 1);
    csr_write(16'h0000);                                  // R3 switch off
    check(status[0] == 0, "R3 switch off", status[0], 0);
    request(1'b1, 16'h00FF, 16'h5A5A, 16'h0, 0);         // R8
    csr_write(16'h0003);                                  // R4 refused, stays off
    check(status[0] == 0, "R4 isolated gate cannot reopen", status[0], 0);
    request(1'b0, 16'hFFFF, 16'h0, 16'h1111, 0);         // R8
    csr_write(PW); csr_write(PW);                         // R2 re-key keeps armed
    csr_write(16'h0003);                                  // R3 on + R6 strobe
    check(status[0] == 1, "R3 switch back on", status[0], 1);
    request(1'b1, 16'hA0A0, 16'h0F0F, 16'h2222, 3);      // R7
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 3) csr_write(PW);
      else if (sel < 6) csr_write(non_key(16'($urandom)));
      else request(1'($urandom), 16'($urandom), 16'($urandom),
                   16'($urandom), $urandom_range(0, 3));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule